// File: doc/BRIEF.md
# Byte-Addressed Memory Bridge over a Word Host Port

This block is a bus master that reaches the 16-bit internal memory of a peripheral through its host port. That port offers four 16-bit registers chosen by a two-bit index. The bridge uses only two of them: the address register and the data register. Each data-register access makes the peripheral move its internal address on by one word (two bytes). On the local side a client asks for a transfer by giving a byte address, a byte count and a direction. For a write, the bridge pulls bytes one at a time from the client. For a read, it pushes bytes out one at a time.

A request becomes one or more sequences. Each sequence writes the address register once and then runs a burst of data-register accesses. A leading byte at an odd address, or a single trailing byte, does not fill a whole word. For a write, such a byte is merged into its word by reading the word and writing it back with only that byte changed. For a read, only the needed half of the word is returned. Two rules apply to every register cycle on the port: the arbitration grant must be high, and a programmable minimum number of clock cycles must separate it from the previous cycle.

Top module: `bpb_bridge`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `rd_valid`, `wr_take` and `port_stb` are all low.
- R2: Two successive `port_stb` pulses are at least `MIN_GAP` cycles apart. The default is 6.
- R3: `port_stb` is never high while `port_gnt` is low.
- R4: Register index 2 is the address register and index 0 is the data register. Each aligned run of whole words is one write of the start byte address to index 2, followed by one index-0 access per word. A word holds the byte at the lower address in bits 7:0. Write bytes are pulled with `wr_take`, one per pulse, sampled from `wr_byte` in that cycle, in ascending address order. The total number of pulses equals the request length.
- R5: For a write that starts at odd address A, the bridge writes A-1 to the address register, reads index 0, writes A-1 again, and then writes index 0. The write-back carries the first byte in bits 15:8 and keeps the old bits 7:0.
- R6: For a read that starts at odd address A, the bridge writes A-1 to the address register, reads index 0 once, and delivers bits 15:8 of that word as the first byte. Read bytes are delivered on `rd_valid`/`rd_byte` in ascending address order.
- R7: When a write leaves one byte after the whole words, the bridge writes the current address, reads index 0, writes the address again, and writes index 0. The write-back keeps the old bits 15:8 and puts the byte in bits 7:0.
- R8: When a read leaves one byte after the whole words, the bridge writes the address, reads index 0, and delivers bits 7:0 as the last byte.
- R9: A write whose address plus length is greater than 0xFFFF is rejected. The bridge raises `done` and `err` together in the first cycle after acceptance and issues no port cycle. A sum of exactly 0xFFFF is carried out normally. Reads are never rejected.
- R10: A zero-length request raises `done` in the first cycle after acceptance, with `err` low and no port cycle.
- R11: A request is accepted only while `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle and low in the cycle after it. `req_valid` raised while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W | Byte count |
| wr_byte | input | 8 | Next write byte, sampled when wr_take is high |
| wr_take | output | 1 | Bridge consumes wr_byte this cycle |
| rd_valid | output | 1 | rd_byte carries a read byte |
| rd_byte | output | 8 | Read byte |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejection, valid with done |
| port_gnt | input | 1 | Port ownership grant |
| port_stb | output | 1 | One-cycle register cycle strobe |
| port_we | output | 1 | Register cycle is a write |
| port_sel | output | 2 | Register index (0 data, 1 mailbox, 2 address, 3 status) |
| port_wdata | output | 16 | Register write value |
| port_rdata | input | 16 | Register read value, valid during the strobe cycle |

## Verification
The close calls are two pairs of events. In the first, the grant falls in the same cycle that the spacing counter expires, and the bridge must hold the cycle instead of issuing it. In the second, a new request strobe arrives while a transfer is still running, including near its final port cycle. The bench drops the grant on a pseudo-random pattern, so drops land on expiry cycles in every transfer. It also pulses a foreign write request into the middle of multi-byte writes. Both are judged at the port: a strobe monitor enforces the grant and spacing rules, and a full compare of the peripheral memory would expose any stray write.

// File: rtl/bpb_pkg.sv
package bpb_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_MBOX = 2'd1;
    localparam logic [1:0] SEL_ADDR = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_H_ADR,
        ST_H_RD,
        ST_H_ADR2,
        ST_H_WR,
        ST_M_ADR,
        ST_M_DAT,
        ST_T_ADR,
        ST_T_RD,
        ST_T_ADR2,
        ST_T_WR,
        ST_FIN
    } seq_state_t;

    typedef enum logic [1:0] {
        EM_PAIR,
        EM_UPPER,
        EM_LOWER
    } emit_kind_t;

    typedef struct packed {
        logic              stb;
        logic              we;
        logic [1:0]        sel;
        logic [WORD_W-1:0] wdata;
    } port_cyc_t;

    // choose the next phase from the current address parity and bytes left
    function automatic seq_state_t pick_phase(input logic odd, input logic many,
                                              input logic one);
        if (odd && (many || one)) return ST_H_ADR;
        if (many)                 return ST_M_ADR;
        if (one)                  return ST_T_ADR;
        return ST_FIN;
    endfunction

endpackage

// File: rtl/bpb_gap_timer.sv
module bpb_gap_timer #(
    parameter int MIN_GAP = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic ready
);
    localparam int CW = $clog2(MIN_GAP + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (fire)
            cnt <= CW'(MIN_GAP - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign ready = (cnt == '0);

    generate
        if (MIN_GAP > 1) begin : g_chk
            AST_GAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
                fire |=> !ready); // R2
        end
    endgenerate

endmodule

// File: rtl/bpb_rd_emitter.sv
module bpb_rd_emitter import bpb_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  emit_kind_t        kind,
    input  logic [WORD_W-1:0] word,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              idle
);
    logic [WORD_W-1:0] hold;
    logic [1:0]        cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            cnt  <= '0;
        end else if (load) begin
            case (kind)
                EM_PAIR:  begin hold <= word;                   cnt <= 2'd2; end
                EM_UPPER: begin hold <= word;                   cnt <= 2'd1; end
                default:  begin hold <= {word[7:0], 8'h00};     cnt <= 2'd1; end
            endcase
        end else if (cnt != 2'd0) begin
            cnt <= cnt - 2'd1;
        end
    end

    assign rd_valid = (cnt != 2'd0);
    assign rd_byte  = (cnt == 2'd2) ? hold[7:0] : hold[15:8];
    assign idle     = (cnt == 2'd0);

    AST_EMIT_NO_CLOBBER: assert property (@(posedge clk) disable iff (rst)
        load |-> cnt != 2'd2); // R4

endmodule

// File: rtl/bpb_sequencer.sv
module bpb_sequencer import bpb_pkg::*; #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_len,
    input  logic              port_gnt,
    input  logic              gap_ready,
    input  logic [WORD_W-1:0] port_rdata,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              emit_idle,
    output port_cyc_t         cyc,
    output logic              wr_take,
    output logic              emit_load,
    output emit_kind_t        emit_kind,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam logic [ADDR_W:0] ADDR_TOP = {1'b0, {ADDR_W{1'b1}}};

    seq_state_t        state;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] rem;
    logic              is_wr;
    logic              rej;
    logic [WORD_W-1:0] rmw;
    logic [BYTE_W-1:0] lo_byte;
    logic              lo_have;

    logic              go;
    logic [ADDR_W-1:0] rem_m1;
    logic [ADDR_W-1:0] rem_m2;
    logic              over_top;

    assign go       = port_gnt && gap_ready;
    assign rem_m1   = rem - ADDR_W'(1);
    assign rem_m2   = rem - ADDR_W'(2);
    assign over_top = ({1'b0, req_addr} + {1'b0, req_len}) > ADDR_TOP;

    always_comb begin
        cyc       = '0;
        cyc.sel   = SEL_ADDR;
        wr_take   = 1'b0;
        emit_load = 1'b0;
        emit_kind = EM_PAIR;
        case (state)
            ST_H_ADR, ST_H_ADR2: begin
                cyc.stb   = go;
                cyc.we    = 1'b1;
                cyc.wdata = WORD_W'(cur_addr - 1'b1);
            end
            ST_M_ADR, ST_T_ADR, ST_T_ADR2: begin
                cyc.stb   = go;
                cyc.we    = 1'b1;
                cyc.wdata = WORD_W'(cur_addr);
            end
            ST_H_RD: begin
                cyc.stb   = go;
                cyc.sel   = SEL_DATA;
                emit_load = go && !is_wr;
                emit_kind = EM_UPPER;
            end
            ST_T_RD: begin
                cyc.stb   = go;
                cyc.sel   = SEL_DATA;
                emit_load = go && !is_wr;
                emit_kind = EM_LOWER;
            end
            ST_H_WR: begin
                cyc.stb   = go;
                cyc.we    = 1'b1;
                cyc.sel   = SEL_DATA;
                cyc.wdata = {wr_byte, rmw[7:0]};
                wr_take   = go;
            end
            ST_T_WR: begin
                cyc.stb   = go;
                cyc.we    = 1'b1;
                cyc.sel   = SEL_DATA;
                cyc.wdata = {rmw[15:8], wr_byte};
                wr_take   = go;
            end
            ST_M_DAT: begin
                cyc.sel = SEL_DATA;
                if (is_wr) begin
                    if (!lo_have) begin
                        wr_take = 1'b1;
                    end else begin
                        cyc.stb   = go;
                        cyc.we    = 1'b1;
                        cyc.wdata = {wr_byte, lo_byte};
                        wr_take   = go;
                    end
                end else begin
                    cyc.stb   = go;
                    emit_load = go;
                    emit_kind = EM_PAIR;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            rem      <= '0;
            is_wr    <= 1'b0;
            rej      <= 1'b0;
            rmw      <= '0;
            lo_byte  <= '0;
            lo_have  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    cur_addr <= req_addr;
                    rem      <= req_len;
                    is_wr    <= req_write;
                    lo_have  <= 1'b0;
                    rej      <= req_write && over_top;
                    if (req_len == '0 || (req_write && over_top))
                        state <= ST_FIN;
                    else
                        state <= pick_phase(req_addr[0], req_len >= ADDR_W'(2),
                                            req_len == ADDR_W'(1));
                end
                ST_H_ADR:  if (go) state <= ST_H_RD;
                ST_H_ADR2: if (go) state <= ST_H_WR;
                ST_M_ADR:  if (go) state <= ST_M_DAT;
                ST_T_ADR:  if (go) state <= ST_T_RD;
                ST_T_ADR2: if (go) state <= ST_T_WR;
                ST_H_RD: if (go) begin
                    rmw <= port_rdata;
                    if (is_wr) begin
                        state <= ST_H_ADR2;
                    end else begin
                        cur_addr <= cur_addr + 1'b1;
                        rem      <= rem_m1;
                        state    <= pick_phase(1'b0, rem_m1 >= ADDR_W'(2),
                                               rem_m1 == ADDR_W'(1));
                    end
                end
                ST_H_WR: if (go) begin
                    cur_addr <= cur_addr + 1'b1;
                    rem      <= rem_m1;
                    state    <= pick_phase(1'b0, rem_m1 >= ADDR_W'(2),
                                           rem_m1 == ADDR_W'(1));
                end
                ST_M_DAT: begin
                    if (is_wr && !lo_have) begin
                        lo_byte <= wr_byte;
                        lo_have <= 1'b1;
                    end else if (go) begin
                        lo_have  <= 1'b0;
                        cur_addr <= cur_addr + ADDR_W'(2);
                        rem      <= rem_m2;
                        if (rem_m2 < ADDR_W'(2))
                            state <= pick_phase(1'b0, 1'b0, rem_m2 == ADDR_W'(1));
                    end
                end
                ST_T_RD: if (go) begin
                    rmw <= port_rdata;
                    if (is_wr) begin
                        state <= ST_T_ADR2;
                    end else begin
                        rem   <= '0;
                        state <= ST_FIN;
                    end
                end
                ST_T_WR: if (go) begin
                    rem   <= '0;
                    state <= ST_FIN;
                end
                ST_FIN: if (emit_idle) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_FIN) && emit_idle;
    assign err  = done && rej;

    AST_ZERO_LEN_FAST: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_valid && req_len == '0) |=> done); // R10

    AST_WRITE_TAKE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_valid && !req_write) |=> !wr_take); // R4

endmodule

// File: rtl/bpb_bridge.sv
module bpb_bridge import bpb_pkg::*; #(
    parameter int ADDR_W  = 16,
    parameter int MIN_GAP = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_len,
    input  logic [7:0]        wr_byte,
    output logic              wr_take,
    output logic              rd_valid,
    output logic [7:0]        rd_byte,
    output logic              busy,
    output logic              done,
    output logic              err,
    input  logic              port_gnt,
    output logic              port_stb,
    output logic              port_we,
    output logic [1:0]        port_sel,
    output logic [15:0]       port_wdata,
    input  logic [15:0]       port_rdata
);
    port_cyc_t  cyc;
    logic       gap_ready;
    logic       emit_load;
    emit_kind_t emit_kind;
    logic       emit_idle;

    bpb_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .port_gnt   (port_gnt),
        .gap_ready  (gap_ready),
        .port_rdata (port_rdata),
        .wr_byte    (wr_byte),
        .emit_idle  (emit_idle),
        .cyc        (cyc),
        .wr_take    (wr_take),
        .emit_load  (emit_load),
        .emit_kind  (emit_kind),
        .busy       (busy),
        .done       (done),
        .err        (err)
    );

    bpb_gap_timer #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk   (clk),
        .rst   (rst),
        .fire  (cyc.stb),
        .ready (gap_ready)
    );

    bpb_rd_emitter u_emit (
        .clk      (clk),
        .rst      (rst),
        .load     (emit_load),
        .kind     (emit_kind),
        .word     (port_rdata),
        .rd_valid (rd_valid),
        .rd_byte  (rd_byte),
        .idle     (emit_idle)
    );

    assign port_stb   = cyc.stb;
    assign port_we    = cyc.we;
    assign port_sel   = cyc.sel;
    assign port_wdata = cyc.wdata;

    AST_STB_NEEDS_GAP: assert property (@(posedge clk) disable iff (rst)
        port_stb |-> gap_ready); // R2

    AST_STB_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        port_stb |-> busy); // R11

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R11

    AST_DONE_AFTER_BYTES: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_valid); // R6

    AST_REJECT_FAST: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(req_valid && !busy)); // R9

    AST_TAKE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_take |-> busy); // R4

endmodule

// File: tb/bpb_bridge_tb.sv
module bpb_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_GAP    = 6;
    localparam int WD_LIMIT   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic [7:0]  wr_byte;
    logic        wr_take, rd_valid, busy, done, err;
    logic [7:0]  rd_byte;
    logic        port_gnt = 1'b1;
    logic        port_stb, port_we;
    logic [1:0]  port_sel;
    logic [15:0] port_wdata, port_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_stb = 0;
    bit have_last = 0;
    int salt = 0;
    int tidx = 0;
    bit take_pend = 0;
    int nrd = 0;
    int n_addr = 0;
    int n_data = 0;
    logic [7:0] lfsr = 8'h5A;
    logic [7:0] rbuf [0:63];
    logic [7:0] refb [0:511];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(input int s, input int i);
        return 8'(s * 37 + i * 11 + 5);
    endfunction

    function automatic logic [7:0] refv(input int b);
        return 8'(b * 29 + 3);
    endfunction

    assign wr_byte = pat(salt, tidx);

    // peripheral model: address register plus auto-advancing data register
    logic [15:0] pmem [0:255];
    logic [15:0] preg;
    assign port_rdata = pmem[preg[8:1]];

    always @(posedge clk) begin
        if (rst) begin
            preg <= '0;
            for (int i = 0; i < 256; i++) pmem[i] <= {refv(2*i+1), refv(2*i)};
        end else if (port_stb) begin
            if (port_sel == 2'd2 && port_we) begin
                preg <= port_wdata;
            end else if (port_sel == 2'd0) begin
                if (port_we) pmem[preg[8:1]] <= port_wdata;
                preg <= preg + 16'd2;
            end
        end
    end

    bpb_bridge #(.ADDR_W(16), .MIN_GAP(MIN_GAP)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len),
        .wr_byte(wr_byte), .wr_take(wr_take),
        .rd_valid(rd_valid), .rd_byte(rd_byte),
        .busy(busy), .done(done), .err(err),
        .port_gnt(port_gnt), .port_stb(port_stb), .port_we(port_we),
        .port_sel(port_sel), .port_wdata(port_wdata), .port_rdata(port_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (take_pend) tidx++;
        take_pend = 0;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        port_gnt = (lfsr[2:0] != 3'd0);
        #1;
        cyc++;
        if (cyc > WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (port_stb) begin
            check(port_gnt, "R3 strobe without grant", 0, 1);
            if (have_last)
                check(cyc - last_stb >= MIN_GAP, "R2 strobe spacing", cyc - last_stb, MIN_GAP);
            last_stb = cyc;
            have_last = 1;
            if (port_sel == 2'd2 && port_we) n_addr++;
            if (port_sel == 2'd0) n_data++;
        end
        if (wr_take) take_pend = 1;
        if (rd_valid) begin
            if (nrd < 64) rbuf[nrd] = rd_byte;
            nrd++;
        end
    endtask

    task automatic do_txn(input int a, input int l, input bit w, input bit exp_rej);
        int k, odd, l1, wd, tl, per, exp_a, exp_d, mism;
        bit poke, err_seen;
        salt++;
        tidx = 0; take_pend = 0; nrd = 0; n_addr = 0; n_data = 0;
        poke = w && (l >= 2) && !exp_rej;
        req_valid = 1'b1;
        req_write = w;
        req_addr  = 16'(a);
        req_len   = 16'(l);
        k = 0;
        do begin
            tick();
            k++;
            if (k == 1) begin
                req_valid = 1'b0;
                check(busy == 1'b1, "R11 busy after accept", int'(busy), 1);
                if (l == 0 || exp_rej)
                    check(done == 1'b1, exp_rej ? "R9 reject latency" : "R10 zero-length latency",
                          int'(done), 1);
            end
            if (poke && k == 3) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0040; req_len = 16'd1;
            end
            if (poke && k == 4) req_valid = 1'b0;
        end while (!done && k < 3000);
        req_valid = 1'b0;
        check(done == 1'b1, "R11 done reached", int'(done), 1);
        err_seen = err;
        check(err_seen == exp_rej, exp_rej ? "R9 err flag" : "R10 err low", int'(err_seen), int'(exp_rej));
        tick();
        check(busy == 1'b0, "R11 busy low after done", int'(busy), 0);

        if (exp_rej || l == 0) begin
            exp_a = 0; exp_d = 0;
        end else begin
            odd = a & 1;
            l1 = l - odd;
            wd = l1 / 2;
            tl = l1 % 2;
            per = w ? 2 : 1;
            exp_a = odd * per + (wd > 0 ? 1 : 0) + tl * per;
            exp_d = odd * per + wd + tl * per;
        end
        check(n_addr == exp_a, exp_rej ? "R9 address writes" : "R4 address writes", n_addr, exp_a);
        check(n_data == exp_d, (a % 2 == 1) ? "R5 data accesses" : "R7 data accesses", n_data, exp_d);

        if (w) begin
            if (!exp_rej)
                for (int i = 0; i < l; i++) refb[(a + i) & 511] = pat(salt, i);
            check(tidx == (exp_rej ? 0 : l), "R4 write bytes taken", tidx, exp_rej ? 0 : l);
            mism = 0;
            for (int i = 0; i < 256; i++)
                if (pmem[i] !== {refb[2*i+1], refb[2*i]}) mism++;
            check(mism == 0, (a % 2 == 1) ? "R5 memory image" : "R7 memory image", mism, 0);
        end else begin
            check(nrd == l, "R6 read byte count", nrd, l);
            mism = 0;
            for (int i = 0; i < l && i < 64; i++)
                if (rbuf[i] !== refb[(a + i) & 511]) mism++;
            check(mism == 0, (a % 2 == 1) ? "R6 read bytes" : "R8 read bytes", mism, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 512; i++) refb[i] = refv(i);
        for (int i = 0; i < 4; i++) tick();
        rst = 1'b0;
        tick();
        check(!busy && !done && !err && !rd_valid && !wr_take && !port_stb,
              "R1 reset state", int'({busy, done, err, rd_valid, wr_take, port_stb}), 0);

        for (int a = 0; a < 10; a++)
            for (int l = 0; l < 8; l++)
                for (int w = 0; w < 2; w++)
                    do_txn(a, l, w[0], 1'b0);

        do_txn(3, 33, 1'b1, 1'b0);
        do_txn(3, 33, 1'b0, 1'b0);
        do_txn(32, 40, 1'b0, 1'b0);
        do_txn(17, 2, 1'b1, 1'b0);
        do_txn(16'hFFF0, 16, 1'b1, 1'b1);
        do_txn(16'hFFFF, 1, 1'b1, 1'b1);
        do_txn(16'hFFF1, 16'hFFFF, 1'b1, 1'b1);
        do_txn(16'hFFF0, 15, 1'b1, 1'b0);
        do_txn(16'hFFF0, 16, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule